// File: doc/BRIEF.md
# Serial Audio Link Frame Engine (Codec Side)

This block is the codec end of a 256-bit time-division serial audio link. It runs on the link bit clock and finds each frame from the rising edge of a frame-sync input. It sends every outgoing bit on a rising clock edge and samples every incoming bit on a falling edge, MSB first. The incoming frame is split into a 16-bit tag, a 20-bit command-address slot, a 20-bit command-data slot and two 20-bit playback slots. The last eight 20-bit slots carry nothing.

Each decoded command becomes a single-cycle strobe toward an external register file. The register file answers a read with combinational data. That data goes back to the controller in the next frame, together with the read address. The outgoing frame also carries a ready flag, per-slot valid flags, two slot-request bits and two record samples. The record samples and the other outgoing fields are captured once, at the first bit of each frame.

Top module: `slink_frame_engine`

## Requirements
- R1: After reset and until the first sync rising edge, `ser_out` stays 0 and no command or playback strobe is asserted.
- R2: A sync low-to-high transition, sampled on a falling edge, starts a frame. Outgoing bit 0, which is tag bit 15, is driven on the next rising edge. A frame lasts 256 bit times. A new sync rise at any position restarts the frame at bit 0.
- R3: The outgoing tag has ready in bit 15. Bits 14 and 13 are both 1 when a read answer is carried. Bits 12 and 11 are the left and right record-valid inputs. Bits 10:0 are 0.
- R4: A write strobe with address = slot1[18:12] and data = slot2[19:4] is issued once, only when tag bits 15, 14 and 13 are all 1 and slot1 bit 19 is 0. Otherwise no write strobe is issued.
- R5: A read strobe with address = slot1[18:12] is issued once when tag bits 15 and 14 are 1 and slot1 bit 19 is 1. Read data is taken while the strobe is high.
- R6: In the frame that follows a read, outgoing slot1[18:12] echoes the address and slot2[19:4] carries the read data. Otherwise both fields are 0. Slot1 bits 11 and 10 are always the inverted want-left and want-right inputs. All other slot1 and slot2 bits are 0.
- R7: Playback slot 3 or 4 produces one strobe with the slot's bits 19:2 (18 bits) when tag bit 15 and the slot's tag bit (12 for left, 11 for right) are both 1. Otherwise no strobe is produced.
- R8: Outgoing slots 3 and 4 hold the 18-bit record sample in bits 19:2, followed by two zero bits, when the sample is valid, and are all zero otherwise. Slots 5 to 12 are all zero.
- R9: All outgoing inputs are captured at the frame's first bit. Changes to them during a frame first appear in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Frame sync from controller |
| ser_in | input | 1 | Serial data from controller |
| ser_out | output | 1 | Serial data to controller |
| ready_in | input | 1 | Codec ready flag to report |
| rec_left | input | 18 | Left record sample |
| rec_left_vld | input | 1 | Left record sample valid |
| rec_right | input | 18 | Right record sample |
| rec_right_vld | input | 1 | Right record sample valid |
| want_left | input | 1 | Request a left playback sample next frame |
| want_right | input | 1 | Request a right playback sample next frame |
| reg_wr_en | output | 1 | Register write strobe |
| reg_rd_en | output | 1 | Register read strobe |
| reg_addr | output | 7 | Register index |
| reg_wdata | output | 16 | Register write data |
| reg_rdata | input | 16 | Register read data, valid during reg_rd_en |
| play_left | output | 18 | Left playback sample |
| play_left_stb | output | 1 | Left playback sample strobe |
| play_right | output | 18 | Right playback sample |
| play_right_stb | output | 1 | Right playback sample strobe |

## Verification
The assertions assume that the controller keeps sync low long enough between frames for a rising edge to be seen. They also assume that the register file returns read data in the same cycle as the read strobe. The stimulus meets both conditions:
- It raises sync only at the last bit time of a frame and lowers it eight bits into the next frame.
- It models the register file as a pure function of the address.

Only two early frame restarts are used, one before the command slots finish and one after the playback slots. This keeps every command either fully received or never started.

// File: rtl/slink_pkg.sv
`timescale 1ns/1ps
package slink_pkg;
  localparam int TAG_W     = 16;
  localparam int SLOT_W    = 20;
  localparam int NUM_SLOTS = 12;
  localparam int FRAME_W   = TAG_W + SLOT_W * NUM_SLOTS;
  localparam int POS_W     = $clog2(FRAME_W);
  localparam int ADDR_W    = 7;
  localparam int DATA_W    = 16;
  localparam int PCM_W     = 18;

  typedef logic [POS_W-1:0]  pos_t;
  typedef logic [SLOT_W-1:0] slot_t;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    slot_t            s1;
    slot_t            s2;
    slot_t            s3;
    slot_t            s4;
  } frame_t;

  // last bit position of a slot; slot 0 is the tag
  function automatic pos_t slot_last(input int slot);
    return pos_t'(TAG_W + SLOT_W * slot - 1);
  endfunction

  // bit that goes on the wire at a given frame position
  function automatic logic frame_bit(input pos_t pos, input frame_t f);
    pos_t       off;
    logic [4:0] idx;
    logic [3:0] tb;
    logic       b;
    b = 1'b0;
    if (pos < pos_t'(TAG_W)) begin
      tb = 4'(TAG_W - 1) - pos[3:0];
      b  = f.tag[tb];
    end else begin
      off = pos - pos_t'(TAG_W);
      idx = 5'(pos_t'(SLOT_W - 1) - (off % pos_t'(SLOT_W)));
      case (off / pos_t'(SLOT_W))
        pos_t'(0): b = f.s1[idx];
        pos_t'(1): b = f.s2[idx];
        pos_t'(2): b = f.s3[idx];
        pos_t'(3): b = f.s4[idx];
        default:   b = 1'b0;
      endcase
    end
    return b;
  endfunction
endpackage

// File: rtl/slink_frame_timer.sv
`timescale 1ns/1ps
module slink_frame_timer
  import slink_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sync_s,
  output logic start,
  output pos_t pos_nx,
  output pos_t cnt,
  output logic locked,
  output logic cap_en
);
  logic sync_d;
  logic sync_rise;
  logic wrap;

  assign sync_rise = sync_s & ~sync_d;
  assign wrap      = locked & (cnt == pos_t'(FRAME_W - 1));
  assign start     = sync_rise | wrap;
  assign pos_nx    = start ? '0 : cnt + pos_t'(1);
  // bit sampled before this edge belongs to position cnt of the running frame
  assign cap_en    = locked & ~start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_d <= 1'b0;
      cnt    <= '0;
      locked <= 1'b0;
    end else begin
      sync_d <= sync_s;
      if (start) locked <= 1'b1;
      if (start | locked) cnt <= pos_nx;
    end
  end

  assert_frame_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !start) |=> (cnt == $past(cnt) + pos_t'(1)));
endmodule

// File: rtl/slink_rx_deframe.sv
`timescale 1ns/1ps
module slink_rx_deframe
  import slink_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  pos_t              cap_idx,
  input  logic              din,
  output logic              wr_en,
  output logic              rd_en,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [PCM_W-1:0]  play_l,
  output logic              play_l_stb,
  output logic [PCM_W-1:0]  play_r,
  output logic              play_r_stb
);
  localparam pos_t END_TAG = slot_last(0);
  localparam pos_t END_S1  = slot_last(1);
  localparam pos_t END_S2  = slot_last(2);
  localparam pos_t END_S3  = slot_last(3);
  localparam pos_t END_S4  = slot_last(4);
  localparam int   TV_W    = 5;   // frame, addr, data, left, right

  logic [SLOT_W-2:0] sh;
  slot_t             nsh;
  logic [TV_W-1:0]   tag_q;
  logic              cmd_read;

  // named decode events
  logic wr_hit, rd_hit, l_hit, r_hit;

  assign nsh    = {sh, din};
  assign wr_hit = cap_en && (cap_idx == END_S2) && tag_q[4] && tag_q[3] && tag_q[2] && !cmd_read;
  assign rd_hit = cap_en && (cap_idx == END_S2) && tag_q[4] && tag_q[3] && cmd_read;
  assign l_hit  = cap_en && (cap_idx == END_S3) && tag_q[4] && tag_q[1];
  assign r_hit  = cap_en && (cap_idx == END_S4) && tag_q[4] && tag_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh         <= '0;
      tag_q      <= '0;
      cmd_read   <= 1'b0;
      cmd_addr   <= '0;
      wr_data    <= '0;
      play_l     <= '0;
      play_r     <= '0;
      wr_en      <= 1'b0;
      rd_en      <= 1'b0;
      play_l_stb <= 1'b0;
      play_r_stb <= 1'b0;
    end else begin
      wr_en      <= wr_hit;
      rd_en      <= rd_hit;
      play_l_stb <= l_hit;
      play_r_stb <= r_hit;
      if (cap_en) sh <= nsh[SLOT_W-2:0];
      if (cap_en && cap_idx == END_TAG) tag_q <= nsh[TAG_W-1 -: TV_W];
      if (cap_en && cap_idx == END_S1) begin
        cmd_read <= nsh[SLOT_W-1];
        cmd_addr <= nsh[SLOT_W-2 -: ADDR_W];
      end
      if (wr_hit) wr_data <= nsh[SLOT_W-1 -: DATA_W];
      if (l_hit)  play_l  <= nsh[SLOT_W-1 -: PCM_W];
      if (r_hit)  play_r  <= nsh[SLOT_W-1 -: PCM_W];
    end
  end

  assert_cmd_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));
  assert_wr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  assert_rd_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);
  assert_play_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (play_l_stb || play_r_stb) |=> !(play_l_stb && play_r_stb));
endmodule

// File: rtl/slink_tx_frame.sv
`timescale 1ns/1ps
module slink_tx_frame
  import slink_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              locked,
  input  pos_t              pos_nx,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              ready,
  input  logic [PCM_W-1:0]  rec_l,
  input  logic              rec_l_vld,
  input  logic [PCM_W-1:0]  rec_r,
  input  logic              rec_r_vld,
  input  logic              want_l,
  input  logic              want_r,
  output logic              ser_out
);
  localparam int REQ_L = SLOT_W - 2 - ADDR_W;
  localparam int REQ_R = REQ_L - 1;

  logic              pend_vld;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;
  frame_t            frame_q, frame_new, frame_use;

  always_comb begin
    frame_new = '0;
    frame_new.tag[TAG_W-1] = ready;
    frame_new.tag[TAG_W-2] = pend_vld;
    frame_new.tag[TAG_W-3] = pend_vld;
    frame_new.tag[TAG_W-4] = rec_l_vld;
    frame_new.tag[TAG_W-5] = rec_r_vld;
    frame_new.s1[REQ_L]    = ~want_l;
    frame_new.s1[REQ_R]    = ~want_r;
    if (pend_vld) begin
      frame_new.s1[SLOT_W-2 -: ADDR_W] = pend_addr;
      frame_new.s2[SLOT_W-1 -: DATA_W] = pend_data;
    end
    if (rec_l_vld) frame_new.s3[SLOT_W-1 -: PCM_W] = rec_l;
    if (rec_r_vld) frame_new.s4[SLOT_W-1 -: PCM_W] = rec_r;
  end

  assign frame_use = start ? frame_new : frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q   <= '0;
      pend_vld  <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
      ser_out   <= 1'b0;
    end else begin
      if (start) begin
        frame_q  <= frame_new;
        pend_vld <= 1'b0;
      end
      if (rd_en) begin
        pend_vld  <= 1'b1;
        pend_addr <= rd_addr;
        pend_data <= rd_data;
      end
      ser_out <= (start | locked) ? frame_bit(pos_nx, frame_use) : 1'b0;
    end
  end

  assert_read_queued_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> pend_vld);
  assert_answer_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !pend_vld) |=> (frame_q.s1[SLOT_W-2 -: ADDR_W] == '0));
endmodule

// File: rtl/slink_frame_engine.sv
`timescale 1ns/1ps
module slink_frame_engine
  import slink_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_in,
  input  logic              ser_in,
  output logic              ser_out,
  input  logic              ready_in,
  input  logic [PCM_W-1:0]  rec_left,
  input  logic              rec_left_vld,
  input  logic [PCM_W-1:0]  rec_right,
  input  logic              rec_right_vld,
  input  logic              want_left,
  input  logic              want_right,
  output logic              reg_wr_en,
  output logic              reg_rd_en,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic [PCM_W-1:0]  play_left,
  output logic              play_left_stb,
  output logic [PCM_W-1:0]  play_right,
  output logic              play_right_stb
);
  logic sync_s, din_s;
  logic start, locked, cap_en;
  pos_t pos_nx, cnt;

  // inputs are taken on the falling edge of the bit clock
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_s <= 1'b0;
      din_s  <= 1'b0;
    end else begin
      sync_s <= sync_in;
      din_s  <= ser_in;
    end
  end

  slink_frame_timer u_timer (
    .clk(clk), .rst_n(rst_n), .sync_s(sync_s), .start(start),
    .pos_nx(pos_nx), .cnt(cnt), .locked(locked), .cap_en(cap_en)
  );

  slink_rx_deframe u_rx (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_idx(cnt), .din(din_s),
    .wr_en(reg_wr_en), .rd_en(reg_rd_en), .cmd_addr(reg_addr), .wr_data(reg_wdata),
    .play_l(play_left), .play_l_stb(play_left_stb),
    .play_r(play_right), .play_r_stb(play_right_stb)
  );

  slink_tx_frame u_tx (
    .clk(clk), .rst_n(rst_n), .start(start), .locked(locked), .pos_nx(pos_nx),
    .rd_en(reg_rd_en), .rd_addr(reg_addr), .rd_data(reg_rdata),
    .ready(ready_in), .rec_l(rec_left), .rec_l_vld(rec_left_vld),
    .rec_r(rec_right), .rec_r_vld(rec_right_vld),
    .want_l(want_left), .want_r(want_right), .ser_out(ser_out)
  );

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (!ser_out && !reg_wr_en && !reg_rd_en && !play_left_stb && !play_right_stb));
  assert_tag_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && cnt == '0) |-> (ser_out == $past(ready_in)));
  assert_tail_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && cnt > slot_last(4)) |-> !ser_out);
endmodule

// File: tb/slink_frame_engine_tb.sv
`timescale 1ns/1ps
module slink_frame_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_in = 1'b0, ser_in = 1'b0;
  logic        ser_out;
  logic        ready_in = 1'b0;
  logic [17:0] rec_left = '0, rec_right = '0;
  logic        rec_left_vld = 1'b0, rec_right_vld = 1'b0;
  logic        want_left = 1'b0, want_right = 1'b0;
  logic        reg_wr_en, reg_rd_en;
  logic [6:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic [17:0] play_left, play_right;
  logic        play_left_stb, play_right_stb;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] rd_fn(input logic [6:0] a);
    return {a, ~a, 2'b10};
  endfunction
  assign reg_rdata = rd_fn(reg_addr);

  slink_frame_engine u_dut (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .ser_in(ser_in), .ser_out(ser_out),
    .ready_in(ready_in), .rec_left(rec_left), .rec_left_vld(rec_left_vld),
    .rec_right(rec_right), .rec_right_vld(rec_right_vld),
    .want_left(want_left), .want_right(want_right),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .play_left(play_left), .play_left_stb(play_left_stb),
    .play_right(play_right), .play_right_stb(play_right_stb)
  );

  int n_tests = 0, n_fail = 0;
  int wr_tot = 0, rd_tot = 0, pl_tot = 0, pr_tot = 0;
  logic [6:0]  wr_a, rd_a;
  logic [15:0] wr_d;
  logic [17:0] pl_v, pr_v;

  always @(negedge clk) if (rst_n) begin
    if (reg_wr_en)      begin wr_tot++; wr_a = reg_addr; wr_d = reg_wdata; end
    if (reg_rd_en)      begin rd_tot++; rd_a = reg_addr; end
    if (play_left_stb)  begin pl_tot++; pl_v = play_left; end
    if (play_right_stb) begin pr_tot++; pr_v = play_right; end
  end

  task automatic chk(input string req, input string what, input logic [255:0] act, input logic [255:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // values applied at bit 100 of a frame when requested (R9)
  logic        nx_ready, nx_lv, nx_rv, nx_wl, nx_wr;
  logic [17:0] nx_rl, nx_rr;

  // expected read answer carried into the next frame
  logic        pend_v = 1'b0;
  logic [6:0]  pend_a = '0;

  task automatic kick();
    @(posedge clk); #1 sync_in = 1'b1;
  endtask

  task automatic send_frame(input logic [15:0] tag, input logic [19:0] s1, s2, s3, s4,
                            input int len, input bit swap, output logic [255:0] cap);
    logic [255:0] tx;
    tx  = {tag, s1, s2, s3, s4, 160'b0};
    cap = '0;
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      ser_in  = tx[255-i];
      sync_in = (i < 8) || (i == len - 1);
      if (swap && i == 100) begin
        ready_in = nx_ready; rec_left_vld = nx_lv; rec_right_vld = nx_rv;
        want_left = nx_wl; want_right = nx_wr; rec_left = nx_rl; rec_right = nx_rr;
      end
      @(negedge clk);
      cap[255-i] = ser_out;
    end
  endtask

  task automatic frame_and_check(input logic [15:0] tag, input logic [19:0] s1, s2, s3, s4,
                                 input int len, input bit swap, input string xreq);
    logic [255:0] exp, cap, mask;
    logic [19:0]  e1, e2, e3, e4;
    int w0, r0, l0, q0;
    bit ewr, erd, epl, epr;
    e1 = {1'b0, pend_v ? pend_a : 7'd0, ~want_left, ~want_right, 10'b0};
    e2 = pend_v ? {rd_fn(pend_a), 4'b0} : 20'd0;
    e3 = rec_left_vld  ? {rec_left, 2'b00}  : 20'd0;
    e4 = rec_right_vld ? {rec_right, 2'b00} : 20'd0;
    exp = {ready_in, pend_v, pend_v, rec_left_vld, rec_right_vld, 11'b0, e1, e2, e3, e4, 160'b0};
    mask = ~({256{1'b1}} >> len);
    w0 = wr_tot; r0 = rd_tot; l0 = pl_tot; q0 = pr_tot;
    send_frame(tag, s1, s2, s3, s4, len, swap, cap);
    chk("R3", "out tag",   256'((cap & mask) >> 240), 256'((exp & mask) >> 240));
    chk("R6", "out slot1", 256'(((cap & mask) >> 220) & 256'hFFFFF), 256'(((exp & mask) >> 220) & 256'hFFFFF));
    chk("R6", "out slot2", 256'(((cap & mask) >> 200) & 256'hFFFFF), 256'(((exp & mask) >> 200) & 256'hFFFFF));
    chk("R8", "out slots3-4", 256'(((cap & mask) >> 160) & 256'hFF_FFFF_FFFF), 256'(((exp & mask) >> 160) & 256'hFF_FFFF_FFFF));
    chk("R8", "out slots5-12", 256'(cap & mask & {96'b0, {160{1'b1}}}), 256'(0));
    if (xreq != "") chk(xreq, "whole frame", cap & mask, exp & mask);
    ewr = tag[15] && tag[14] && tag[13] && !s1[19] && len > 60;
    erd = tag[15] && tag[14] && s1[19] && len > 60;
    epl = tag[15] && tag[12] && len > 100;
    epr = tag[15] && tag[11] && len > 100;
    chk("R4", "write count", 256'(wr_tot - w0), 256'(ewr));
    if (ewr) chk("R4", "write addr/data", 256'({wr_a, wr_d}), 256'({s1[18:12], s2[19:4]}));
    chk("R5", "read count", 256'(rd_tot - r0), 256'(erd));
    if (erd) chk("R5", "read addr", 256'(rd_a), 256'(s1[18:12]));
    chk("R7", "left strobes", 256'(pl_tot - l0), 256'(epl));
    if (epl) chk("R7", "left sample", 256'(pl_v), 256'(s3[19:2]));
    chk("R7", "right strobes", 256'(pr_tot - q0), 256'(epr));
    if (epr) chk("R7", "right sample", 256'(pr_v), 256'(s4[19:2]));
    pend_v = erd;
    pend_a = s1[18:12];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic idle_bad;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: quiet until first sync
    idle_bad = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ser_out !== 1'b0) idle_bad = 1'b1;
    end
    chk("R1", "ser_out idle", 256'(idle_bad), 256'(0));
    chk("R1", "strobes idle", 256'(wr_tot + rd_tot + pl_tot + pr_tot), 256'(0));

    kick();
    // sweep every tag-valid combination and both command directions
    for (int n = 0; n < 64; n++) begin
      logic [5:0] k;
      k = 6'(n);
      ready_in = k[0] ^ k[3]; rec_left_vld = k[1]; rec_right_vld = k[2];
      want_left = k[3]; want_right = k[4];
      rec_left = 18'(n * 2749 + 5); rec_right = 18'(~(n * 811));
      frame_and_check({k[4:0], 11'b0}, {k[5], 7'(n * 5 + 3), 12'b0},
                      {16'(n * 1237 + 4369), 4'b0}, 20'(n * 7919 ^ 703710),
                      20'(n * 3571 + 12345), 256, 1'b0, "");
    end

    // R2: frame cut at 40 bits, full write tag must not commit
    ready_in = 1'b1; rec_left_vld = 1'b1; rec_right_vld = 1'b0;
    want_left = 1'b0; want_right = 1'b1; rec_left = 18'h2A5A5;
    frame_and_check(16'hF800, {1'b0, 7'h55, 12'b0}, {16'hBEEF, 4'b0}, 20'hFFFFF, 20'h12345, 40, 1'b0, "R2");
    // R2: frame cut at 120 bits after a read and both playback slots
    frame_and_check(16'hD800, {1'b1, 7'h2A, 12'b0}, 20'd0, 20'hABCDF, 20'h54323, 120, 1'b0, "R2");
    // R9: inputs change mid-frame, read answer from previous frame carried
    nx_ready = 1'b0; nx_lv = 1'b0; nx_rv = 1'b1; nx_wl = 1'b1; nx_wr = 1'b0;
    nx_rl = 18'h00001; nx_rr = 18'h3C3C3;
    frame_and_check(16'h0000, 20'd0, 20'd0, 20'd0, 20'd0, 256, 1'b1, "R9");
    frame_and_check(16'h8000, 20'd0, 20'd0, 20'd0, 20'd0, 256, 1'b0, "R9");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule